// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two 16-bit count channels for a small embedded controller. Each channel is stored as a low byte and a high byte. A channel counts one of two things. In timer mode it counts a machine-cycle tick, which is produced by dividing the input clock. In counter mode it counts falling edges on its own external input. Software drives the block through a byte-wide register port. It chooses the source, gating and counting mode of each channel, starts and stops the channels, and reads or clears the overflow flags. Those flags are also driven onto two output pins so that interrupt logic outside the block can use them.

Each channel has four counting shapes:
- a 13-bit count;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split shape.

In the split shape, channel 0 becomes two separate 8-bit counters. The second of these counters borrows the run bit and the overflow flag of channel 1. Channel 1 put into the split shape freezes.

Top module: `dual_tmr`

## Requirements
- R1: After reset, all six registers read 0x00 and both `ovf_flag` bits are 0.
- R2: The register map is: address 0 = channel 0 low byte, 1 = channel 0 high byte, 2 = channel 1 low byte, 3 = channel 1 high byte, 4 = mode register, 5 = control register. Addresses 6 and 7 read 0x00. Bits 3:0 of the control register read 0. A write to a count byte takes priority over a count that lands on the same byte in the same cycle.
- R3: A machine-cycle tick occurs once every 12 clocks. The first tick falls on the 12th rising edge after reset is released. A running timer-mode channel advances exactly once per tick, and count bytes change only on a tick or a register write.
- R4: The counter-mode input passes through a two-flop synchroniser and is then sampled once per tick. The channel advances on the tick at which the sample is 0 and the previous tick's sample was 1.
- R5: The mode register holds one nibble per channel, with channel 0 in bits 3:0. Within a nibble, bit 3 = gate enable, bit 2 = source (1 = external edges), and bits 1:0 = mode. The control register holds bit 7 = channel 1 flag, bit 6 = channel 1 run, bit 5 = channel 0 flag and bit 4 = channel 0 run. A channel counts only while its run bit is 1 and either its gate enable is 0 or its `gate_in` bit is 1.
- R6: Mode 0 counts the 13-bit value formed by the high byte and bits 4:0 of the low byte. In this mode, bits 7:5 of the low byte read 0 and are stored as 0 on every count. Passing from 0x1FFF to 0 sets the channel's flag.
- R7: Mode 1 counts the full 16 bits. Passing from 0xFFFF to 0 sets the channel's flag.
- R8: Mode 2 counts the low byte only. When the low byte passes 0xFF, it is loaded from the high byte, the high byte is left unchanged, and the channel's flag is set.
- R9: Mode 3 on channel 0 splits it into two counters. The low byte counts under channel 0's run, gate and source settings and sets flag 0 when it passes 0xFF. The high byte counts ticks while channel 1's run bit is 1, ignoring gate and source, and sets flag 1 when it passes 0xFF.
- R10: Mode 3 on channel 1 holds both of its bytes. While channel 0 is in mode 3, channel 1's own overflow does not set flag 1.
- R11: The flags stay set until software changes them. A control write loads bits 7:4 from the written data. An overflow in the same cycle as a control write still leaves its flag at 1. `ovf_flag[1]` reflects control bit 7 and `ovf_flag[0]` reflects bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_in | input | 2 | External count inputs, one per channel |
| gate_in | input | 2 | Gate inputs, one per channel |
| ovf_flag | output | 2 | Overflow flags {channel 1, channel 0} |

## Verification
The hold properties take for granted that a count byte can only be altered by a tick or by a strobe on the register port. For that reason they are conditioned on `reg_we` being low. The edge properties assume the count inputs are asynchronous but slow, with each level lasting at least one machine cycle. The stimulus drives every input on the falling clock edge. It keeps each count-input level for 13 to 30 clocks, so that no edge falls below the minimum width.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;

  typedef enum logic [1:0] {
    MD_13     = 2'd0,
    MD_16     = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate_en;
    logic   ext_src;
    tmode_e mode;
  } chcfg_t;

  // {carry, hi, lo}; the three upper low-byte bits come back as zero
  function automatic logic [16:0] adv13(input logic [7:0] hi, input logic [7:0] lo);
    logic [13:0] s;
    s = {1'b0, hi, lo[4:0]} + 14'd1;
    return {s[13], s[12:5], 3'b000, s[4:0]};
  endfunction

  function automatic logic [16:0] adv16(input logic [7:0] hi, input logic [7:0] lo);
    return {1'b0, hi, lo} + 17'd1;
  endfunction

  function automatic logic [8:0] adv8(input logic [7:0] v);
    return {1'b0, v} + 9'd1;
  endfunction
endpackage

// File: rtl/dtc_prescaler.sv
`timescale 1ns/1ps
module dtc_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtc_edge.sv
`timescale 1ns/1ps
module dtc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];
  assign fall  = tick & prev_q & ~level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      if (tick) prev_q <= level;
    end
  end
endmodule

// File: rtl/dtc_channel.sv
`timescale 1ns/1ps
module dtc_channel
  import dtc_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic [1:0]        ovf
);
  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [16:0]       r16;
  logic [8:0]        r8l, r8h;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    ovf  = 2'b00;
    r16  = '0;
    r8l  = adv8(lo);
    r8h  = adv8(hi);
    unique case (mode)
      MD_13: begin
        r16 = adv13(hi, lo);
        if (inc_lo) begin
          {hi_n, lo_n} = r16[15:0];
          ovf[0]       = r16[16];
        end
      end
      MD_16: begin
        r16 = adv16(hi, lo);
        if (inc_lo) begin
          {hi_n, lo_n} = r16[15:0];
          ovf[0]       = r16[16];
        end
      end
      MD_RELOAD: begin
        if (inc_lo) begin
          lo_n   = r8l[8] ? hi : r8l[7:0];
          ovf[0] = r8l[8];
        end
      end
      MD_SPLIT: begin
        if (SPLIT_OK) begin
          if (inc_lo) begin
            lo_n   = r8l[7:0];
            ovf[0] = r8l[8];
          end
          if (inc_hi) begin
            hi_n   = r8h[7:0];
            ovf[1] = r8h[8];
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end
endmodule

// File: rtl/dual_tmr.sv
`timescale 1ns/1ps
module dual_tmr
  import dtc_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [1:0]        cnt_in,
  input  logic [1:0]        gate_in,
  output logic [1:0]        ovf_flag
);
  localparam int NCH = 2;

  // observable internal events
  logic            mc_tick;
  logic [NCH-1:0]  ch_fall;
  logic            wr_ctrl;
  logic            inc0_lo, inc0_hi, inc1;

  logic [7:0]      mode_q;
  logic [NCH-1:0]  tr_q, tf_q, tf_set;
  logic [7:0]      tl0, th0, tl1, th1;
  logic [1:0]      ovf0, ovf1;
  chcfg_t          cfg0, cfg1;
  logic            split0;

  assign cfg0   = chcfg_t'(mode_q[3:0]);
  assign cfg1   = chcfg_t'(mode_q[7:4]);
  assign split0 = (cfg0.mode == MD_SPLIT);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

  dtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_edge
    dtc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick),
      .pin(cnt_in[i]), .fall(ch_fall[i])
    );
  end

  function automatic logic gated_inc(input chcfg_t c, input logic run,
                                     input logic gpin, input logic edge_ev,
                                     input logic tk);
    return run & (~c.gate_en | gpin) & (c.ext_src ? edge_ev : tk);
  endfunction

  assign inc0_lo = gated_inc(cfg0, tr_q[0], gate_in[0], ch_fall[0], mc_tick);
  assign inc0_hi = mc_tick & tr_q[1];
  assign inc1    = gated_inc(cfg1, tr_q[1], gate_in[1], ch_fall[1], mc_tick);

  dtc_channel #(.SPLIT_OK(1'b1)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .mode(cfg0.mode),
    .inc_lo(inc0_lo), .inc_hi(inc0_hi),
    .wr_lo(reg_we && reg_addr == A_LO0), .wr_hi(reg_we && reg_addr == A_HI0),
    .wdata(reg_wdata), .lo(tl0), .hi(th0), .ovf(ovf0)
  );

  dtc_channel #(.SPLIT_OK(1'b0)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .mode(cfg1.mode),
    .inc_lo(inc1), .inc_hi(1'b0),
    .wr_lo(reg_we && reg_addr == A_LO1), .wr_hi(reg_we && reg_addr == A_HI1),
    .wdata(reg_wdata), .lo(tl1), .hi(th1), .ovf(ovf1)
  );

  assign tf_set[0] = ovf0[0];
  assign tf_set[1] = split0 ? ovf0[1] : (|ovf1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      tr_q   <= '0;
      tf_q   <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) mode_q <= reg_wdata;
      if (wr_ctrl) begin
        tr_q <= {reg_wdata[6], reg_wdata[4]};
        tf_q <= {reg_wdata[7], reg_wdata[5]} | tf_set;
      end else begin
        tf_q <= tf_q | tf_set;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_LO0:   reg_rdata = (cfg0.mode == MD_13) ? {3'b000, tl0[4:0]} : tl0;
      A_HI0:   reg_rdata = th0;
      A_LO1:   reg_rdata = (cfg1.mode == MD_13) ? {3'b000, tl1[4:0]} : tl1;
      A_HI1:   reg_rdata = th1;
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], 4'b0000};
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = tf_q;
endmodule

// File: rtl/dtc_checker.sv
`timescale 1ns/1ps
module dtc_checker #(
  parameter int PRESCALE = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] fall,
  input logic       we,
  input logic       wr_ctrl,
  input logic       inc0,
  input logic [7:0] mode_q,
  input logic [7:0] tl0,
  input logic [7:0] th0,
  input logic [7:0] tl1,
  input logic [7:0] th1,
  input logic [1:0] tf
);
  logic [15:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 16'd1;
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 16'(PRESCALE - 1)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable({tl0, th0, tl1, th1}));

  p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |-> tick);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && inc0 && !we) |=> (tl0[7:5] == 3'b000));

  p_ch1_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !we) |=> $stable({tl1, th1}));

  p_flag0_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tf[0] && !wr_ctrl) |=> tf[0]);

  p_flag1_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tf[1] && !wr_ctrl) |=> tf[1]);
endmodule

bind dual_tmr dtc_checker #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(mc_tick), .fall(ch_fall),
  .we(reg_we), .wr_ctrl(wr_ctrl), .inc0(inc0_lo), .mode_q(mode_q),
  .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1), .tf(tf_q)
);

// File: tb/dual_tmr_tb.sv
`timescale 1ns/1ps
module dual_tmr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_in = '0;
  logic [1:0] gate_in = '0;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  dual_tmr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
    .gate_in(gate_in), .ovf_flag(ovf_flag)
  );

  always #5 clk = ~clk;

  // ---------------- reference model, written from the requirements
  int         m_pc;
  logic [1:0] m_s1, m_s2, m_prev;
  logic [7:0] m_tl0, m_th0, m_tl1, m_th1, m_mode;
  logic       m_tr0, m_tr1, m_tf0, m_tf1;

  function automatic void b_adv(input int md, input bit can_split,
                                input bit up_lo, input bit up_hi,
                                inout logic [7:0] lo, inout logic [7:0] hi,
                                output bit c_lo, output bit c_hi);
    int v;
    c_lo = 0; c_hi = 0;
    case (md)
      0: if (up_lo) begin
           v = int'(hi) * 32 + int'(lo % 32) + 1;
           c_lo = (v == 8192); v = v % 8192;
           hi = 8'(v / 32); lo = 8'(v % 32);
         end
      1: if (up_lo) begin
           v = int'(hi) * 256 + int'(lo) + 1;
           c_lo = (v == 65536); v = v % 65536;
           hi = 8'(v / 256); lo = 8'(v % 256);
         end
      2: if (up_lo) begin
           if (lo == 8'hFF) begin lo = hi; c_lo = 1; end
           else lo = lo + 8'd1;
         end
      default: if (can_split) begin
           if (up_lo) begin c_lo = (lo == 8'hFF); lo = lo + 8'd1; end
           if (up_hi) begin c_hi = (hi == 8'hFF); hi = hi + 8'd1; end
         end
    endcase
  endfunction

  always @(posedge clk) begin
    bit tk, e0, e1, i0, i1, ih, a0, b0, a1, b1, s0, s1;
    bit [1:0] fl;
    if (!rst_n) begin
      m_pc = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_tl0 = 0; m_th0 = 0; m_tl1 = 0; m_th1 = 0; m_mode = 0;
      m_tr0 = 0; m_tr1 = 0; m_tf0 = 0; m_tf1 = 0;
    end else begin
      tk = (m_pc == 11);
      m_pc = tk ? 0 : m_pc + 1;
      for (int i = 0; i < 2; i++) begin
        fl[i] = tk && m_prev[i] && !m_s2[i];
        if (tk) m_prev[i] = m_s2[i];
      end
      m_s2 = m_s1; m_s1 = cnt_in;
      e0 = m_tr0 && (!m_mode[3] || gate_in[0]);
      e1 = m_tr1 && (!m_mode[7] || gate_in[1]);
      i0 = e0 && (m_mode[2] ? fl[0] : tk);
      i1 = e1 && (m_mode[6] ? fl[1] : tk);
      ih = tk && m_tr1;
      b_adv(int'(m_mode[1:0]), 1, i0, ih, m_tl0, m_th0, a0, b0);
      b_adv(int'(m_mode[5:4]), 0, i1, 0, m_tl1, m_th1, a1, b1);
      s0 = a0;
      s1 = (m_mode[1:0] == 2'b11) ? b0 : a1;
      if (reg_we && reg_addr == 3'd5) begin
        m_tf1 = reg_wdata[7] | s1; m_tr1 = reg_wdata[6];
        m_tf0 = reg_wdata[5] | s0; m_tr0 = reg_wdata[4];
      end else begin
        m_tf1 = m_tf1 | s1; m_tf0 = m_tf0 | s0;
      end
      if (reg_we) case (reg_addr)
        3'd0: m_tl0 = reg_wdata;
        3'd1: m_th0 = reg_wdata;
        3'd2: m_tl1 = reg_wdata;
        3'd3: m_th1 = reg_wdata;
        3'd4: m_mode = reg_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: return (m_mode[1:0] == 2'b00) ? (m_tl0 & 8'h1F) : m_tl0;
      1: return m_th0;
      2: return (m_mode[5:4] == 2'b00) ? (m_tl1 & 8'h1F) : m_tl1;
      3: return m_th1;
      4: return m_mode;
      5: return {m_tf1, m_tr1, m_tf0, m_tr0, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- helpers
  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    @(posedge clk); #1;
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #0;
      #0.5;
      check(tag, $sformatf("reg[%0d]", a), reg_rdata, m_read(a));
    end
    check(tag, "ovf_flag", {6'b0, ovf_flag}, {6'b0, m_tf1, m_tf0});
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      repeat (12) @(negedge clk);
      check_all(tag);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  // ---------------- stimulus
  initial begin
    int hold0, hold1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2 map, reserved bits, write priority
    wr(0, 8'h5A); wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'hC3);
    wr(4, 8'h11); wr(5, 8'h0F);
    check_all("R2");

    // R3 / R7: channel 0 16-bit timer near wrap
    wr(4, 8'h01); wr(0, 8'hF0); wr(1, 8'hFF); wr(5, 8'h10);
    run(20, "R7");
    check_all("R3");
    wr(5, 8'h00);

    // R6: 13-bit with upper low-byte bits set by a write
    wr(4, 8'h00); wr(0, 8'hFC); wr(1, 8'hFF); wr(5, 8'h10);
    run(8, "R6");
    wr(5, 8'h00);

    // R8: reload
    wr(4, 8'h02); wr(1, 8'hF0); wr(0, 8'hFC); wr(5, 8'h10);
    run(30, "R8");
    wr(5, 8'h00);

    // R9: split channel 0, channel 1 16-bit
    wr(4, 8'h13); wr(0, 8'hF8); wr(1, 8'hFA); wr(2, 8'hF0); wr(3, 8'hFF);
    wr(5, 8'h50);
    run(20, "R9");
    wr(5, 8'h00);

    // R10: channel 1 in mode 3 holds
    wr(4, 8'h31); wr(2, 8'h12); wr(3, 8'h34); wr(5, 8'h50);
    run(10, "R10");
    wr(5, 8'h00);

    // R4: counter source on both channels
    wr(4, 8'h55); wr(0, 8'hFA); wr(1, 8'hFF); wr(2, 8'h00); wr(3, 8'h00);
    wr(5, 8'h50);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); cnt_in = ~cnt_in;
      repeat (15) @(negedge clk);
      check_all("R4");
    end
    wr(5, 8'h00);

    // R5: gate enabled, pulsed
    wr(4, 8'h99); wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    wr(5, 8'h50);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); gate_in = 2'(k);
      repeat (30) @(negedge clk);
      check_all("R5");
    end

    // R11: flag write-clear and hardware set
    wr(5, 8'hF0);
    check_all("R11");
    wr(5, 8'h50);
    check_all("R11");

    // constrained random
    hold0 = 20; hold1 = 20;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (--hold0 == 0) begin cnt_in[0] = ~cnt_in[0]; hold0 = 13 + int'($urandom % 18); end
      if (--hold1 == 0) begin cnt_in[1] = ~cnt_in[1]; hold1 = 13 + int'($urandom % 18); end
      if ($urandom % 50 == 0) gate_in = 2'($urandom);
      if ($urandom % 40 == 0) begin
        reg_we = 1'b1; reg_addr = 3'($urandom); reg_wdata = 8'($urandom);
      end else begin
        reg_we = 1'b0;
      end
      if (k % 50 == 49) begin
        @(negedge clk); reg_we = 1'b0;
        check_all("R11");
      end
    end
    @(negedge clk); reg_we = 1'b0;
    check_all("R2");
    report();
  end
endmodule